// File: doc/BRIEF.md
# Programmable Word-Wide Logic Cell

This block is one cell of a coarse-grained fabric for bus-shaped data. It holds N identical bit slices, and all of them read one configuration word. Each slice takes one bit from each of three operand buses plus a carry-in. It passes those four signals through two 16-entry truth tables. The first table gives the result bit and the second gives the carry that goes to the next slice up. Because every slice runs the same function, the cell acts as an N-bit adder, comparator, mask unit or bitwise operator, depending on the two tables it has been given.

Each operand bus first passes through its own zero-filling shifter. The carry into bit 0 comes from a selectable source. The carry out of the top bit is exported as a status flag for an outside sequencer. The result bus can be taken from a register in each slice or straight from the tables. Configuration is loaded one bit per clock through a serial chain. The configuration in use is held steady while a new one is loaded.

Top module: `wordcell`

## Requirements
- R1: After synchronous reset the configuration is all zeros. With zero inputs, `result` reads 0 and `carry_out` reads 0.
- R2: While `cfg_load` is 1, each rising edge shifts `cfg_din` into the top bit of a CFGW-bit shadow word, and the other bits move down one place. After CFGW edges, the first bit sent sits at bit 0. For N=8 the field layout from bit 0 upward is: result table [15:0], carry table [31:16], carry-in select [33:32], register enable [34], then shifters A [38:35], B [42:39] and C [46:43]. In each shifter field the low SHW bits are the amount and the top bit is the direction.
- R3: While `cfg_load` is 1 the configuration in use does not change, so the outputs follow the old function. On the first rising edge with `cfg_load` at 0, the shadow word becomes the configuration in use.
- R4: Result bit i equals result_table[{cin_i, C_i, B_i, A_i}], where A, B and C are the shifted operand buses. Every bit uses the same table.
- R5: The carry into bit i+1 equals carry_table[{cin_i, C_i, B_i, A_i}]. `carry_out` is the carry out of bit N-1.
- R6: The carry-in select sets the carry into bit 0: 0 gives constant 0, 1 gives constant 1, 2 gives `ctrl_cin`, and 3 gives constant 0.
- R7: Direction 0 shifts toward the MSB and direction 1 shifts toward the LSB, by the given amount. Vacated positions are filled with zeros. An amount of 0 passes the bus through unchanged, and an amount of N or more gives zero.
- R8: With the register enable at 1, `result` shows the table outputs captured at the previous rising edge. With it at 0, `result` follows the current inputs in the same cycle.
- R9: `carry_out` is always combinational from the current inputs, whatever the register enable is set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Serial configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| bus_a | input | N | Operand bus A |
| bus_b | input | N | Operand bus B |
| bus_c | input | N | Operand bus C |
| ctrl_cin | input | 1 | External carry-in for bit 0 |
| result | output | N | Result word |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
A misplaced or stale configuration bit changes the function in every bit position at once. The next operand vector after the load finishes therefore produces a result word that is wrong in a way that follows the pattern of the table. A fault in the carry chain shows only in patterns that propagate a carry, so wide adder patterns are needed to expose it in `carry_out` and the upper result bits. A bad slice register shows one cycle late, and only in registered mode. A configuration that takes effect too early shows as the outputs changing while `cfg_load` is still high.

// File: rtl/wordcell_pkg.sv
package wordcell_pkg;
  localparam int TBL_W = 16;
  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_EXT  = 2'd2,
    CIN_RSVD = 2'd3
  } cin_src_e;
endpackage

// File: rtl/wordcell_shifter.sv
module wordcell_shifter #(
  parameter int N   = 8,
  parameter int SHW = 3
) (
  input  logic [N-1:0]   din,
  input  logic           to_lsb,
  input  logic [SHW-1:0] amt,
  output logic [N-1:0]   dout
);
  always_comb begin
    if (32'(amt) >= N)
      dout = '0;
    else if (to_lsb)
      dout = din >> amt;
    else
      dout = din << amt;
  end
endmodule

// File: rtl/wordcell_slice.sv
module wordcell_slice
  import wordcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             op_a,
  input  logic             op_b,
  input  logic             op_c,
  input  logic             cin,
  input  logic [TBL_W-1:0] res_tbl,
  input  logic [TBL_W-1:0] cry_tbl,
  input  logic             use_reg,
  output logic             f_comb,
  output logic             res,
  output logic             cout
);
  logic [3:0] idx;
  logic       q;

  assign idx    = {cin, op_c, op_b, op_a};
  assign f_comb = res_tbl[idx];
  assign cout   = cry_tbl[idx];

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= f_comb;
  end

  assign res = use_reg ? q : f_comb;
endmodule

// File: rtl/wordcell_cfg_chain.sv
module wordcell_cfg_chain #(
  parameter int CFGW = 47
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            din,
  output logic [CFGW-1:0] active
);
  logic [CFGW-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      active <= '0;
    end else if (load) begin
      shadow <= {din, shadow[CFGW-1:1]};
    end else begin
      active <= shadow;
    end
  end

  AST_CFG_SHIFT: assert property (@(posedge clk) disable iff (rst)
    load |=> (shadow[CFGW-2:0] == $past(shadow[CFGW-1:1]))); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    load |=> $stable(active)); // R3
  AST_CFG_APPLY: assert property (@(posedge clk) disable iff (rst)
    !load |=> (active == $past(shadow))); // R3
endmodule

// File: rtl/wordcell.sv
module wordcell
  import wordcell_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_load,
  input  logic         cfg_din,
  input  logic [N-1:0] bus_a,
  input  logic [N-1:0] bus_b,
  input  logic [N-1:0] bus_c,
  input  logic         ctrl_cin,
  output logic [N-1:0] result,
  output logic         carry_out
);
  localparam int SHW     = (N > 1) ? $clog2(N) : 1;
  localparam int SFW     = SHW + 1;
  localparam int OFF_RES = 0;
  localparam int OFF_CRY = OFF_RES + TBL_W;
  localparam int OFF_CIN = OFF_CRY + TBL_W;
  localparam int OFF_REG = OFF_CIN + 2;
  localparam int OFF_SH  = OFF_REG + 1;
  localparam int CFGW    = OFF_SH + 3 * SFW;

  logic [CFGW-1:0]  cfg;
  logic [TBL_W-1:0] res_tbl, cry_tbl;
  cin_src_e         cin_src;
  logic             use_reg;
  logic [N-1:0]     ops_in  [3];
  logic [N-1:0]     ops_sh  [3];
  logic [N:0]       carry;
  logic [N-1:0]     comb_word;

  wordcell_cfg_chain #(.CFGW(CFGW)) u_chain (
    .clk(clk), .rst(rst), .load(cfg_load), .din(cfg_din), .active(cfg)
  );

  assign res_tbl = cfg[OFF_RES +: TBL_W];
  assign cry_tbl = cfg[OFF_CRY +: TBL_W];
  assign cin_src = cin_src_e'(cfg[OFF_CIN +: 2]);
  assign use_reg = cfg[OFF_REG];

  assign ops_in[0] = bus_a;
  assign ops_in[1] = bus_b;
  assign ops_in[2] = bus_c;

  for (genvar k = 0; k < 3; k++) begin : g_shift
    wordcell_shifter #(.N(N), .SHW(SHW)) u_sh (
      .din   (ops_in[k]),
      .to_lsb(cfg[OFF_SH + k*SFW + SHW]),
      .amt   (cfg[OFF_SH + k*SFW +: SHW]),
      .dout  (ops_sh[k])
    );
  end

  always_comb begin
    unique case (cin_src)
      CIN_ONE: carry[0] = 1'b1;
      CIN_EXT: carry[0] = ctrl_cin;
      default: carry[0] = 1'b0;
    endcase
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    wordcell_slice u_slice (
      .clk    (clk),
      .rst    (rst),
      .op_a   (ops_sh[0][i]),
      .op_b   (ops_sh[1][i]),
      .op_c   (ops_sh[2][i]),
      .cin    (carry[i]),
      .res_tbl(res_tbl),
      .cry_tbl(cry_tbl),
      .use_reg(use_reg),
      .f_comb (comb_word[i]),
      .res    (result[i]),
      .cout   (carry[i+1])
    );
  end

  assign carry_out = carry[N];

  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cry_tbl == '0) |-> !carry_out); // R5
  AST_REG_PATH: assert property (@(posedge clk) disable iff (rst)
    (use_reg && $past(use_reg) && $stable(cfg)) |-> (result == $past(comb_word))); // R8
  AST_FILL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!cfg[OFF_SH + SHW] && cfg[OFF_SH +: SHW] != '0) |-> !ops_sh[0][0]); // R7
  AST_COMB_PATH: assert property (@(posedge clk) disable iff (rst)
    !use_reg |-> (result == comb_word)); // R8
endmodule

// File: tb/wordcell_test.sv
module wordcell_test;
  localparam int N    = 8;
  localparam int SHW  = 3;
  localparam int SFW  = 4;
  localparam int CFGW = 47;

  logic clk = 0, rst = 1, cfg_load = 0, cfg_din = 0, ctrl_cin = 0;
  logic [N-1:0] bus_a = 0, bus_b = 0, bus_c = 0;
  logic [N-1:0] result;
  logic carry_out;
  int checks = 0, errors = 0;
  bit done = 0;

  wordcell #(.N(N)) uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_din(cfg_din),
    .bus_a(bus_a), .bus_b(bus_b), .bus_c(bus_c), .ctrl_cin(ctrl_cin),
    .result(result), .carry_out(carry_out)
  );

  always #5 clk = ~clk;

  function automatic logic [CFGW-1:0] mkcfg(logic [15:0] rt, logic [15:0] ct,
      logic [1:0] cs, logic reg_en, logic [SFW-1:0] fa, logic [SFW-1:0] fb, logic [SFW-1:0] fc);
    return {fc, fb, fa, reg_en, cs, ct, rt};
  endfunction

  function automatic logic [N-1:0] shf(logic [N-1:0] v, logic [SFW-1:0] f);
    int amt = int'(f[SHW-1:0]);
    if (amt >= N) return '0;
    return f[SHW] ? (v >> amt) : (v << amt);
  endfunction

  function automatic logic [N:0] model(logic [CFGW-1:0] c, logic [N-1:0] a,
      logic [N-1:0] b, logic [N-1:0] cc, logic ext);
    logic [N-1:0] sa, sb, sc, r;
    logic cy;
    sa = shf(a, c[35 +: SFW]);
    sb = shf(b, c[39 +: SFW]);
    sc = shf(cc, c[43 +: SFW]);
    case (c[33:32])
      2'd1: cy = 1'b1;
      2'd2: cy = ext;
      default: cy = 1'b0;
    endcase
    for (int i = 0; i < N; i++) begin
      logic [3:0] ix;
      ix = {cy, sc[i], sb[i], sa[i]};
      r[i] = c[ix];
      cy = c[16 + ix];
    end
    return {cy, r};
  endfunction

  function automatic logic [15:0] tbl_xor3();
    logic [15:0] t;
    for (int i = 0; i < 16; i++) t[i] = i[0] ^ i[1] ^ i[3];
    return t;
  endfunction

  function automatic logic [15:0] tbl_maj();
    logic [15:0] t;
    for (int i = 0; i < 16; i++) t[i] = (i[0] & i[1]) | (i[0] & i[3]) | (i[1] & i[3]);
    return t;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(logic [CFGW-1:0] c, bit hold_chk, logic [N:0] hold_val);
    for (int i = 0; i < CFGW; i++) begin
      @(negedge clk);
      cfg_load = 1;
      cfg_din = c[i];
      #1;
      if (hold_chk) check("R3 hold during load", {carry_out, result}, hold_val);
    end
    @(negedge clk);
    cfg_load = 0;
    @(negedge clk);
  endtask

  task automatic apply_comb(logic [CFGW-1:0] c, logic [N-1:0] a, logic [N-1:0] b,
      logic [N-1:0] cc, logic e, string req);
    logic [N:0] m;
    @(negedge clk);
    bus_a = a; bus_b = b; bus_c = cc; ctrl_cin = e;
    #1;
    m = model(c, a, b, cc, e);
    check(req, {carry_out, result}, m);
  endtask

  task automatic apply_reg(logic [CFGW-1:0] c, logic [N-1:0] a, logic [N-1:0] b,
      logic [N-1:0] cc, logic e, string req);
    logic [N:0] m;
    @(negedge clk);
    bus_a = a; bus_b = b; bus_c = cc; ctrl_cin = e;
    m = model(c, a, b, cc, e);
    #1;
    check("R9 carry comb in reg mode", carry_out, m[N]);
    @(posedge clk);
    #1;
    check(req, {carry_out, result}, m);
  endtask

  initial begin
    logic [CFGW-1:0] cadd, cpass, ccin, crnd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check("R1 reset result", result, 0);
    check("R1 reset carry", carry_out, 0);

    cadd = mkcfg(tbl_xor3(), tbl_maj(), 2'd0, 1'b0, 4'd0, 4'd0, 4'd0);
    load_cfg(cadd, 0, 0);
    apply_comb(cadd, 8'd200, 8'd100, 8'd0, 1'b0, "R4 adder wrap");
    check("R5 adder 200+100", {carry_out, result}, 9'h12C);
    apply_comb(cadd, 8'hFF, 8'h01, 8'h00, 1'b0, "R5 full ripple");
    check("R5 ripple carry_out", carry_out, 1);

    cpass = mkcfg(16'hAAAA, 16'h0000, 2'd0, 1'b0, 4'b1011, 4'd0, 4'd0);
    apply_comb(cadd, 8'd200, 8'd100, 8'd0, 1'b0, "R4 adder again");
    load_cfg(cpass, 1, 9'h12C);
    apply_comb(cpass, 8'hF0, 8'h00, 8'h00, 1'b0, "R7 right shift 3");
    check("R7 right shift value", result, 8'h1E);
    cpass = mkcfg(16'hAAAA, 16'h0000, 2'd0, 1'b0, 4'b0101, 4'd0, 4'd0);
    load_cfg(cpass, 0, 0);
    apply_comb(cpass, 8'hFF, 8'h00, 8'h00, 1'b0, "R7 left shift 5");
    check("R7 left shift value", result, 8'hE0);
    cpass = mkcfg(16'hAAAA, 16'h0000, 2'd0, 1'b0, 4'b0000, 4'd0, 4'd0);
    load_cfg(cpass, 0, 0);
    apply_comb(cpass, 8'h5C, 8'h00, 8'h00, 1'b0, "R7 amount zero");

    for (int s = 0; s < 4; s++) begin
      ccin = mkcfg(16'hFF00, 16'hFF00, s[1:0], 1'b0, 4'd0, 4'd0, 4'd0);
      load_cfg(ccin, 0, 0);
      for (int e = 0; e < 2; e++) begin
        apply_comb(ccin, 8'h00, 8'h00, 8'h00, e[0], "R6 carry-in source");
        check("R6 source value", {carry_out, result},
              (s == 1 || (s == 2 && e == 1)) ? 9'h1FF : 9'h000);
      end
    end

    cadd = mkcfg(tbl_xor3(), tbl_maj(), 2'd0, 1'b1, 4'd0, 4'd0, 4'd0);
    load_cfg(cadd, 0, 0);
    apply_reg(cadd, 8'd3, 8'd4, 8'd0, 1'b0, "R8 registered");
    @(negedge clk);
    bus_a = 8'd10; bus_b = 8'd20;
    #1;
    check("R8 holds previous", result, 8'd7);
    check("R9 carry follows now", carry_out, 0);
    @(posedge clk); #1;
    check("R8 updates after edge", result, 8'd30);

    for (int n = 0; n < 30; n++) begin
      crnd = {$urandom(), $urandom()};
      load_cfg(crnd, 0, 0);
      for (int v = 0; v < 12; v++) begin
        logic [N-1:0] ra, rb, rc;
        logic re;
        ra = N'($urandom()); rb = N'($urandom()); rc = N'($urandom());
        re = 1'($urandom());
        if (crnd[34]) apply_reg(crnd, ra, rb, rc, re, "R4/R5 random reg");
        else          apply_comb(crnd, ra, rb, rc, re, "R4/R5 random comb");
      end
    end

    rst = 1;
    @(negedge clk);
    rst = 0;
    bus_a = 0; bus_b = 0; bus_c = 0;
    #1;
    check("R1 re-reset result", {carry_out, result}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule